// File: doc/BRIEF.md
# I2C bus clock and phase sequencer

This block is the bit-level timing engine of an I2C master. It drives the open-drain SCL and SDA pins through two pull-low enables, reads both lines back, and carries out four bus operations on request: START, repeated START, STOP and the transfer of a single data bit. Byte framing, acknowledge handling and any buffering belong to the logic that issues the requests.

All bus timing is counted in system-clock cycles and comes from four independent settings: the full bit period, the SCL low time, the setup/hold time used around START and STOP conditions, and the data setup time, which is how long SDA is valid before SCL is released. The SCL high time is the bit period minus the low time. To run the bus at a given rate, the bit period is the system clock divided by that rate. Typical values are a low time and a START/STOP time of half the period, and a data setup time of one sixteenth of it. A target may stretch the clock by holding SCL low. While it does, the phases that run with SCL released stop counting.

The requester presents an operation when `ready` is high. It receives a one-cycle `done` when the operation has finished. After a data bit, the value sampled from SDA in the middle of the high phase appears on `rxBit`.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset both pull-low enables are off (`sclOe`=0, `sdaOe`=0), `ready`=1, `done`=0 and `rxBit`=0.
- R2: A START (opcode 0) is accepted on a clock edge with `ready` and `reqValid` high. At that edge `sdaOe` goes to 1 while SCL stays released. `sclOe` goes to 1 max(S,1) edges later (S = setup/hold setting), and `done` rises at that same edge.
- R3: For a data bit (opcode 3, value `reqBit`), `sdaOe` takes the value NOT `reqBit` at the edge that comes A edges after acceptance. A = low time minus data setup when that difference is positive, and 1 otherwise. `sclOe` falls max(D,1) edges after that (D = data setup), so SDA never changes in the same edge as the SCL release.
- R4: The SCL high phase of a data bit lasts H edges, where H = period minus low time when that is positive and 1 otherwise, plus any stretch cycles. At its end `sclOe` returns to 1 and `done` rises at that same edge.
- R5: During a data bit, `rxBit` captures the SDA line level in the non-stretched high-phase cycle with index floor(H/2), counting from 0. It holds that value until the next data bit.
- R6: While SCL is released by the block but `sclIn` reads low, the counter of the current high-side phase (bit high, START/STOP setup, START hold) does not advance. Each such cycle lengthens that phase by one.
- R7: A repeated START (opcode 2) first sets `sdaOe`=0 after A edges and releases SCL D edges later. After max(S,1) high cycles plus any stretch it sets `sdaOe`=1. It sets `sclOe`=1 and raises `done` max(S,1) edges after that.
- R8: A STOP (opcode 1) sets `sdaOe`=1 after A edges and releases SCL D edges later. After max(S,1) high cycles plus any stretch it sets `sdaOe`=0 and raises `done` at that edge, leaving both lines released.
- R9: `ready` is low from acceptance until the edge that raises `done`. `done` is high for exactly one cycle, and `ready` is high in that cycle. A `reqValid` presented while `ready` is low has no effect on timing or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPeriod | input | CNT_W | Bit period in clock cycles |
| cfgLow | input | CNT_W | SCL low time in clock cycles |
| cfgStopSetup | input | CNT_W | START/STOP setup and hold time in clock cycles |
| cfgDataSetup | input | CNT_W | SDA valid time before SCL release |
| reqValid | input | 1 | Operation request |
| reqKind | input | 2 | Operation: 0 START, 1 STOP, 2 repeated START, 3 data bit |
| reqBit | input | 1 | Bit value to send with a data bit operation |
| sclIn | input | 1 | SCL line readback |
| sdaIn | input | 1 | SDA line readback |
| ready | output | 1 | Idle and able to accept an operation |
| done | output | 1 | One-cycle completion pulse |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| rxBit | output | 1 | SDA value sampled in the last data bit |

## Verification
The hardest case to reach is clock stretching that meets each of the three high-side phases at its first released cycle and lasts a known number of cycles. The bench models the target as a pull-down that is armed before the request and releases SCL after a chosen count of released cycles. It then expects every later edge to move by exactly that count. A second hard case is the set of settings that collapse a phase to one cycle: low time not above data setup, period equal to low time, and zero setup values. Directed transactions cover these. Requests are also held active during a busy operation to show that they leave the timing untouched.

// File: rtl/scl_pkg.sv
package scl_pkg;

  typedef enum logic [1:0] {
    OP_START   = 2'd0,
    OP_STOP    = 2'd1,
    OP_RESTART = 2'd2,
    OP_BIT     = 2'd3
  } opKind_e;

  typedef enum logic [1:0] {
    SEL_LOWA = 2'd0,
    SEL_DSU  = 2'd1,
    SEL_HIGH = 2'd2,
    SEL_SSU  = 2'd3
  } phaseSel_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOWA  = 3'd1,
    ST_LOWB  = 3'd2,
    ST_HIGH  = 3'd3,
    ST_SETUP = 3'd4,
    ST_HOLD  = 3'd5
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic      cntClr;
    phaseSel_e sel;
    logic      watchScl;
    logic      sampleEn;
    logic      sclDrv;
    logic      sclRel;
    logic      sdaWr;
    logic      sdaVal;
  } dpCtl_t;

endpackage

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgStopSetup,
  input  logic [CNT_W-1:0] cfgDataSetup,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             phaseEnd,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             rxBit
);

  localparam int EXT_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] lowALen;
  logic [CNT_W-1:0] highLen;
  logic [CNT_W-1:0] midPt;
  logic [CNT_W-1:0] target;
  logic [CNT_W-1:0] cnt;
  logic             hold;

  // derived phase lengths; non-positive differences collapse to one cycle
  always_comb begin
    lowALen = (cfgLow > cfgDataSetup) ? (cfgLow - cfgDataSetup) : ONE;
    highLen = (cfgPeriod > cfgLow) ? (cfgPeriod - cfgLow) : ONE;
    midPt   = highLen >> 1;
    unique case (ctl.sel)
      SEL_LOWA: target = lowALen;
      SEL_DSU:  target = cfgDataSetup;
      SEL_HIGH: target = highLen;
      default:  target = cfgStopSetup;
    endcase
  end

  // stretching: released but still read low
  assign hold     = ctl.watchScl && !sclIn;
  assign phaseEnd = !hold && ((EXT_W'(cnt) + EXT_W'(1)) >= EXT_W'(target));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClr) begin
      cnt <= '0;
    end else if (!hold) begin
      cnt <= cnt + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
      rxBit <= 1'b0;
    end else begin
      if (ctl.sclDrv) begin
        sclOe <= 1'b1;
      end else if (ctl.sclRel) begin
        sclOe <= 1'b0;
      end
      if (ctl.sdaWr) begin
        sdaOe <= ctl.sdaVal;
      end
      if (ctl.sampleEn && !hold && (cnt == midPt)) begin
        rxBit <= sdaIn;
      end
    end
  end

endmodule

// File: rtl/scl_timing_ctl.sv
module scl_timing_ctl
  import scl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqBit,
  input  logic       phaseEnd,
  output dpCtl_t     ctl,
  output logic       ready,
  output logic       done
);

  seqState_e state, stateNext;
  opKind_e   opQ;
  logic      bitQ;
  logic      finish;
  logic      accept;

  assign ready  = (state == ST_IDLE);
  assign accept = ready && reqValid;

  always_comb begin
    ctl        = '0;
    ctl.sel    = SEL_LOWA;
    ctl.cntClr = phaseEnd;
    stateNext  = state;
    finish     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ctl.cntClr = 1'b1;
        if (reqValid) begin
          if (opKind_e'(reqKind) == OP_START) begin
            ctl.sdaWr  = 1'b1;
            ctl.sdaVal = 1'b1;
            stateNext  = ST_HOLD;
          end else begin
            stateNext = ST_LOWA;
          end
        end
      end
      ST_LOWA: begin
        ctl.sel = SEL_LOWA;
        if (phaseEnd) begin
          ctl.sdaWr = 1'b1;
          unique case (opQ)
            OP_BIT:     ctl.sdaVal = !bitQ;
            OP_RESTART: ctl.sdaVal = 1'b0;
            default:    ctl.sdaVal = 1'b1;
          endcase
          stateNext = ST_LOWB;
        end
      end
      ST_LOWB: begin
        ctl.sel = SEL_DSU;
        if (phaseEnd) begin
          ctl.sclRel = 1'b1;
          stateNext  = (opQ == OP_BIT) ? ST_HIGH : ST_SETUP;
        end
      end
      ST_HIGH: begin
        ctl.sel      = SEL_HIGH;
        ctl.watchScl = 1'b1;
        ctl.sampleEn = 1'b1;
        if (phaseEnd) begin
          ctl.sclDrv = 1'b1;
          stateNext  = ST_IDLE;
          finish     = 1'b1;
        end
      end
      ST_SETUP: begin
        ctl.sel      = SEL_SSU;
        ctl.watchScl = 1'b1;
        if (phaseEnd) begin
          ctl.sdaWr = 1'b1;
          if (opQ == OP_RESTART) begin
            ctl.sdaVal = 1'b1;
            stateNext  = ST_HOLD;
          end else begin
            ctl.sdaVal = 1'b0;
            stateNext  = ST_IDLE;
            finish     = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        ctl.sel      = SEL_SSU;
        ctl.watchScl = 1'b1;
        if (phaseEnd) begin
          ctl.sclDrv = 1'b1;
          stateNext  = ST_IDLE;
          finish     = 1'b1;
        end
      end
      default: begin
        stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opQ   <= OP_START;
      bitQ  <= 1'b0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (accept) begin
        opQ  <= opKind_e'(reqKind);
        bitQ <= reqBit;
      end
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgLow,
  input  logic [CNT_W-1:0] cfgStopSetup,
  input  logic [CNT_W-1:0] cfgDataSetup,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             reqBit,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             ready,
  output logic             done,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             rxBit
);

  dpCtl_t ctl;
  logic   phaseEnd;

  scl_timing_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .reqBit   (reqBit),
    .phaseEnd (phaseEnd),
    .ctl      (ctl),
    .ready    (ready),
    .done     (done)
  );

  scl_timing_dp #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .cfgPeriod    (cfgPeriod),
    .cfgLow       (cfgLow),
    .cfgStopSetup (cfgStopSetup),
    .cfgDataSetup (cfgDataSetup),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .phaseEnd     (phaseEnd),
    .sclOe        (sclOe),
    .sdaOe        (sdaOe),
    .rxBit        (rxBit)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic done,
  input logic sclOe,
  input logic sdaOe,
  input logic sclIn
);

  // R9: completion lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: completion coincides with being idle
  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);

  // R6: a stretched released SCL is not pulled low again
  p_stretch_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ready && !sclOe && !sclIn) |=> !sclOe);

  // R3: SDA never moves at the edge that releases SCL
  p_sda_setup_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!sclOe && $past(sclOe)) |-> $stable(sdaOe));

  // R7/R8: SDA moves with SCL released only when SCL was really high
  p_cond_scl_high_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaOe) && !$past(sclOe) && !$past(ready)) |-> $past(sclIn));

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .ready (ready),
  .done  (done),
  .sclOe (sclOe),
  .sdaOe (sdaOe),
  .sclIn (sclIn)
);

// File: tb/scl_timing_gen_tb.sv
module scl_timing_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [CNT_W-1:0] cfgPeriod, cfgLow, cfgStopSetup, cfgDataSetup;
  logic       reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic       reqBit = 1'b0;
  logic       ready, done, sclOe, sdaOe, rxBit;
  logic       slaveHold = 1'b0;
  logic       slaveSda = 1'b0;
  logic       sclIn, sdaIn;
  int         stretchW = 0;
  int         heldCnt = 0;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 1'b0;

  assign sclIn = !sclOe && !slaveHold;
  assign sdaIn = !sdaOe && !slaveSda;

  scl_timing_gen #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .cfgPeriod(cfgPeriod), .cfgLow(cfgLow),
    .cfgStopSetup(cfgStopSetup), .cfgDataSetup(cfgDataSetup),
    .reqValid(reqValid), .reqKind(reqKind), .reqBit(reqBit),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .ready(ready), .done(done), .sclOe(sclOe), .sdaOe(sdaOe), .rxBit(rxBit)
  );

  function automatic int effA();
    return (cfgLow > cfgDataSetup) ? int'(cfgLow - cfgDataSetup) : 1;
  endfunction
  function automatic int effD();
    return (cfgDataSetup == 0) ? 1 : int'(cfgDataSetup);
  endfunction
  function automatic int effH();
    return (cfgPeriod > cfgLow) ? int'(cfgPeriod - cfgLow) : 1;
  endfunction
  function automatic int effS();
    return (cfgStopSetup == 0) ? 1 : int'(cfgStopSetup);
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // kind: 0 START, 1 STOP, 2 repeated START, 3 data bit
  task automatic runOp(input int kind, input bit b, input int w, input bit sSda, input bit junk);
    int  t, sclFirst, sclLast, sdaLast, doneT;
    int  a, d, h, s;
    bit  prevScl, prevSda, preSda, sawReady;
    a = effA(); d = effD(); h = effH(); s = effS();
    prevScl = sclOe; prevSda = sdaOe; preSda = sdaOe; sawReady = 1'b0;
    reqValid  = 1'b1;
    reqKind   = 2'(kind);
    reqBit    = b;
    slaveSda  = (kind == 3) ? sSda : 1'b0;
    slaveHold = (w > 0) && (kind != 0);
    heldCnt   = 0;
    stretchW  = w;
    sclFirst = -1; sclLast = -1; sdaLast = -1; doneT = -1;
    @(posedge clk);
    t = 0;
    while (doneT < 0 && t < 5000) begin
      @(negedge clk);
      if (junk) begin
        reqKind = 2'($urandom);
        reqBit  = 1'($urandom);
      end else begin
        reqValid = 1'b0;
      end
      if (slaveHold && !sclOe) begin
        if (heldCnt == stretchW) slaveHold = 1'b0;
        else heldCnt++;
      end
      if (sclOe != prevScl) begin
        if (sclFirst < 0) sclFirst = t;
        sclLast = t;
        prevScl = sclOe;
      end
      if (sdaOe != prevSda) begin
        sdaLast = t;
        prevSda = sdaOe;
      end
      if (done) begin
        doneT    = t;
        reqValid = 1'b0;
      end else if (ready) begin
        sawReady = 1'b1;
      end
      t++;
    end
    check("R9", "ready while busy", int'(sawReady), 0);
    unique case (kind)
      0: begin
        check("R2", "sda pull edge", sdaLast, 0);
        check("R2", "scl pull edge", sclLast, s);
        check("R2", "done edge", doneT, s);
        check("R2", "final sclOe", int'(sclOe), 1);
      end
      3: begin
        check("R3", "scl release edge", sclFirst, a + d);
        if (preSda != !b) check("R3", "sda change edge", sdaLast, a);
        check("R3", "sdaOe value", int'(sdaOe), int'(!b));
        check("R4", "scl pull edge", sclLast, a + d + h + w);
        check("R6", "done edge with stretch", doneT, a + d + h + w);
        check("R5", "sampled bit", int'(rxBit), int'(b & !sSda));
      end
      2: begin
        check("R7", "scl release edge", sclFirst, a + d);
        check("R7", "sda pull edge", sdaLast, a + d + s + w);
        check("R7", "scl pull edge", sclLast, a + d + 2 * s + w);
        check("R7", "done edge", doneT, a + d + 2 * s + w);
        check("R7", "final sdaOe", int'(sdaOe), 1);
      end
      default: begin
        check("R8", "scl release edge", sclFirst, a + d);
        check("R8", "sda release edge", sdaLast, a + d + s + w);
        check("R8", "done edge", doneT, a + d + s + w);
        check("R8", "final lines", int'({sclOe, sdaOe}), 0);
      end
    endcase
    @(negedge clk);
    check("R9", "done one cycle", int'(done), 0);
    slaveSda  = 1'b0;
    slaveHold = 1'b0;
  endtask

  task automatic runTxn(input bit junk, input int wMax);
    int nb;
    runOp(0, 1'b0, 0, 1'b0, junk);
    nb = 1 + int'($urandom % 6);
    for (int i = 0; i < nb; i++)
      runOp(3, 1'($urandom), int'($urandom % (wMax + 1)), 1'($urandom), junk);
    if ($urandom % 2 == 1) begin
      runOp(2, 1'b0, int'($urandom % (wMax + 1)), 1'b0, junk);
      for (int i = 0; i < 3; i++)
        runOp(3, 1'($urandom), int'($urandom % (wMax + 1)), 1'($urandom), junk);
    end
    runOp(1, 1'b0, int'($urandom % (wMax + 1)), 1'b0, junk);
  endtask

  task automatic setCfg(input int p, input int l, input int s, input int d);
    cfgPeriod    = CNT_W'(p);
    cfgLow       = CNT_W'(l);
    cfgStopSetup = CNT_W'(s);
    cfgDataSetup = CNT_W'(d);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      report();
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    setCfg(40, 20, 20, 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "sclOe", int'(sclOe), 0);
    check("R1", "sdaOe", int'(sdaOe), 0);
    check("R1", "ready", int'(ready), 1);
    check("R1", "done", int'(done), 0);
    check("R1", "rxBit", int'(rxBit), 0);

    // directed corner settings
    setCfg(40, 20, 20, 3);   runTxn(1'b0, 0);
    setCfg(30, 12, 6, 0);    runTxn(1'b0, 2);   // zero data setup
    setCfg(30, 3, 5, 5);     runTxn(1'b0, 1);   // low time not above setup
    setCfg(16, 16, 0, 2);    runTxn(1'b0, 3);   // high collapses, zero S
    setCfg(10, 20, 1, 1);    runTxn(1'b0, 0);   // period below low
    setCfg(24, 12, 12, 1);   runTxn(1'b0, 9);   // long stretches
    setCfg(24, 12, 7, 2);    runTxn(1'b1, 2);   // R9 requests while busy

    // random settings and traffic
    for (int k = 0; k < 40; k++) begin
      int l;
      l = 2 + int'($urandom % 30);
      setCfg(l + 1 + int'($urandom % 30), l, int'($urandom % 20),
             int'($urandom % l));
      runTxn(1'($urandom % 4 == 0), 4);
    end

    if (!finished) begin
      finished = 1'b1;
      report();
      $finish;
    end
  end

endmodule